// File: doc/BRIEF.md
# Multi-Bank Flash Command Dispatcher

This block is the global command front end of a flash device whose array is split into independent banks. The host first writes an operation code. It then presents an address together with any write data. An address-change detector turns each valid, new address into one command. The command takes the stored operation code and is steered to the bank named by the top address bits. Each bank has its own local controller, which is outside this block and appears only as start/done ports. Because of this, one bank can be programming while another erases or reads.

When the target bank is idle and nothing is waiting for it, the command launches on that bank's port in the very next cycle. When the bank is busy, or already has commands waiting, the command, its address and its data go into that bank's private queue. The bank drains its queue by itself each time its local controller reports completion, with no host involvement, and strictly in arrival order. If any bank queue is full, the block drops its host ready signal. An address offered while ready is low is not taken.

Top module: `flash_cmd_dispatch`

## Requirements
- R1: After reset, host_ready is 1, op_err is 0 and no bank start is asserted.
- R2: Writing op_in with op_we stores it when it is 00 (read), 01 (program) or 10 (erase). Code 11 leaves the stored code unchanged and makes op_err high for exactly the one cycle after the write.
- R3: With addr_vld high, an address becomes a command only if it differs from the last accepted address, or if a valid opcode write has occurred since that acceptance. A repeated address produces no command.
- R4: No address is accepted before the first valid opcode write after reset.
- R5: A command goes only to the bank given by addr_in[7:6]. That bank's start is asserted with bk_op, bk_addr and bk_wdata equal to the stored opcode, the accepted address and the write data presented with it. Bank b occupies slice [2b+1:2b] of bk_op and slice [8b+7:8b] of the address and data buses.
- R6: A command for a bank that is idle, or that asserts bk_done in the same cycle, and whose queue is empty asserts that bank's start in the cycle right after acceptance.
- R7: A command for a busy bank, or for a bank with queued entries, is held in that bank's queue. The head entry starts in the cycle after the bank is seen idle or asserting bk_done.
- R8: Commands to one bank start in the order they were accepted.
- R9: host_ready is 0 while any bank queue holds 4 entries. An address presented while host_ready is 0 is ignored.
- R10: Banks run independently. Different banks may start in the same cycle, and a busy bank never delays another bank.
- R11: A bank start is a one-cycle pulse. No further start occurs on a bank that is busy until it asserts bk_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_we | input | 1 | Opcode write strobe |
| op_in | input | 2 | Opcode value |
| addr_vld | input | 1 | Address bus holds a valid address |
| addr_in | input | AW | Command address; top bits select the bank |
| wdata_in | input | DW | Write data sent with the address |
| host_ready | output | 1 | Low while any bank queue is full |
| op_err | output | 1 | One-cycle pulse after an unsupported opcode write |
| bk_done | input | NB | Per-bank completion from the local controllers |
| bk_start | output | NB | Per-bank one-cycle launch pulse |
| bk_op | output | 2*NB | Per-bank launched opcode |
| bk_addr | output | AW*NB | Per-bank launched address |
| bk_wdata | output | DW*NB | Per-bank launched write data |

## Verification
The same edge can see a bank finish (bk_done) while a new command for that bank arrives. In that edge the dispatcher must either bypass the queue or pop its head, and in the second case it pushes and pops the queue at once. Another bank can launch from its own queue in that same edge. The bench runs local controllers with random latencies and sends a random mix of addresses over a few hot banks, so all of these coincidences happen often. It judges them cycle by cycle against its own queue-and-busy model of every bank, comparing which banks start and what each start carries.

// File: rtl/fd_pkg.sv
// Shared opcode encoding for the flash command dispatcher.
package fd_pkg;

    typedef enum logic [1:0] {
        FD_OP_READ  = 2'b00,
        FD_OP_PROG  = 2'b01,
        FD_OP_ERASE = 2'b10,
        FD_OP_RSVD  = 2'b11
    } fd_op_e;

    // True for the operation codes the local controllers accept.
    function automatic logic fd_op_ok(input logic [1:0] code);
        return (code == FD_OP_READ) || (code == FD_OP_PROG) || (code == FD_OP_ERASE);
    endfunction

endpackage

// File: rtl/fd_opcode_atd.sv
// Opcode register and address-change detector.
// Holds the last valid opcode. Each valid address that differs from the last
// accepted one becomes a one-cycle command strobe (fire). A valid opcode write
// rearms the detector so that the same address may be used again.
// Assumes the host holds addr_in and wdata_in steady while addr_vld is high.
module fd_opcode_atd
    import fd_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_we,
    input  logic [1:0]    op_in,
    input  logic          addr_vld,
    input  logic [AW-1:0] addr_in,
    input  logic          accept_ok,
    output logic          fire,
    output logic [1:0]    cur_op,
    output logic          op_err
);

    logic [1:0]    op_q;
    logic          loaded_q;
    logic          armed_q;
    logic [AW-1:0] last_q;
    logic          err_q;

    // Accept a valid, new address when an opcode is present and there is room.
    always_comb begin
        fire = addr_vld && accept_ok && loaded_q && (armed_q || (addr_in != last_q));
    end

    // Opcode storage, detector memory and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= FD_OP_READ;
            loaded_q <= 1'b0;
            armed_q  <= 1'b0;
            last_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= op_we && !fd_op_ok(op_in);
            if (fire) begin
                last_q  <= addr_in;
                armed_q <= 1'b0;
            end
            if (op_we && fd_op_ok(op_in)) begin
                op_q     <= op_in;
                loaded_q <= 1'b1;
                armed_q  <= 1'b1;
            end
        end
    end

    assign cur_op = op_q;
    assign op_err = err_q;

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> $past(op_we) && ($past(op_in) == FD_OP_RSVD)); // R2

    AST_NO_FIRE_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded_q |-> !fire); // R4

endmodule

// File: rtl/fd_cmd_fifo.sv
// Per-bank command queue: a small circular buffer of packed commands.
// Push and pop may occur in the same cycle. The caller never pushes when
// full and never pops when empty. DEPTH must be a power of two.
module fd_cmd_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = PW + 1;

    logic [W-1:0]    mem [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [CNTW-1:0] count;

    // Storage write; no reset is needed because count guards the reads.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNTW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full || pop); // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R7

endmodule

// File: rtl/fd_bank_seq.sv
// Per-bank launch sequencer.
// Tracks whether the local controller is busy. It launches the queue head
// when the bank is free, or bypasses the queue when the queue is empty and a
// command for this bank arrives. Otherwise it pushes the arrival. The bank
// counts as free in the cycle it reports done.
// Assumes bk_done is asserted only while the bank is busy, and not in the
// cycle of its start pulse.
module fd_bank_seq #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arrive,
    input  logic [W-1:0] arrive_cmd,
    input  logic         q_empty,
    input  logic [W-1:0] q_head,
    input  logic         done,
    output logic         q_push,
    output logic         q_pop,
    output logic         start,
    output logic [W-1:0] launch_cmd
);

    logic         busy_q;
    logic         start_q;
    logic [W-1:0] cmd_q;
    logic         free;
    logic         bypass;

    // Decide between popping, bypassing and queueing.
    always_comb begin
        free   = !busy_q || done;
        q_pop  = free && !q_empty;
        bypass = free && q_empty && arrive;
        q_push = arrive && !bypass;
    end

    // Launch register and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            cmd_q   <= '0;
        end else begin
            start_q <= q_pop || bypass;
            if (q_pop) begin
                cmd_q <= q_head;
            end else if (bypass) begin
                cmd_q <= arrive_cmd;
            end
            if (q_pop || bypass) begin
                busy_q <= 1'b1;
            end else if (done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign start      = start_q;
    assign launch_cmd = cmd_q;

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !done |=> !start_q); // R11

    AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy_q); // R11

    AST_QUEUE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !q_empty && free |=> start_q && (launch_cmd == $past(q_head))); // R8

endmodule

// File: rtl/flash_cmd_dispatch.sv
// Global command dispatcher for a multi-bank flash array.
// Combines the opcode latch and address-change detector with one queue and
// one launch sequencer per bank. The bank is chosen by the top address bits.
// host_ready falls while any bank queue is full.
// Assumes NB and QDEPTH are powers of two.
module flash_cmd_dispatch
    import fd_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int NB     = 4,
    parameter int QDEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_we,
    input  logic [1:0]       op_in,
    input  logic             addr_vld,
    input  logic [AW-1:0]    addr_in,
    input  logic [DW-1:0]    wdata_in,
    output logic             host_ready,
    output logic             op_err,
    input  logic [NB-1:0]    bk_done,
    output logic [NB-1:0]    bk_start,
    output logic [2*NB-1:0]  bk_op,
    output logic [AW*NB-1:0] bk_addr,
    output logic [DW*NB-1:0] bk_wdata
);

    localparam int BW = (NB > 1) ? $clog2(NB) : 1;
    localparam int CW = 2 + AW + DW;

    logic          fire;
    logic [1:0]    cur_op;
    logic [CW-1:0] in_cmd;
    logic [BW-1:0] tgt;
    logic [NB-1:0] q_full;
    logic [NB-1:0] q_empty;
    logic [NB-1:0] q_push;
    logic [NB-1:0] q_pop;

    // Pack the arriving command and pick its bank.
    always_comb begin
        in_cmd     = {cur_op, addr_in, wdata_in};
        tgt        = addr_in[AW-1 -: BW];
        host_ready = ~|q_full;
    end

    fd_opcode_atd #(.AW(AW)) u_atd (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_we     (op_we),
        .op_in     (op_in),
        .addr_vld  (addr_vld),
        .addr_in   (addr_in),
        .accept_ok (host_ready),
        .fire      (fire),
        .cur_op    (cur_op),
        .op_err    (op_err)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [CW-1:0] head;
        logic [CW-1:0] launch_cmd;
        logic          arrive;

        assign arrive = fire && (tgt == BW'(b));

        fd_cmd_fifo #(.W(CW), .DEPTH(QDEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[b]),
            .din   (in_cmd),
            .pop   (q_pop[b]),
            .head  (head),
            .empty (q_empty[b]),
            .full  (q_full[b])
        );

        fd_bank_seq #(.W(CW)) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .arrive     (arrive),
            .arrive_cmd (in_cmd),
            .q_empty    (q_empty[b]),
            .q_head     (head),
            .done       (bk_done[b]),
            .q_push     (q_push[b]),
            .q_pop      (q_pop[b]),
            .start      (bk_start[b]),
            .launch_cmd (launch_cmd)
        );

        assign bk_op[2*b +: 2]     = launch_cmd[CW-1 -: 2];
        assign bk_addr[AW*b +: AW] = launch_cmd[DW +: AW];
        assign bk_wdata[DW*b +: DW] = launch_cmd[DW-1:0];
    end

    AST_READY_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |-> !fire); // R9

    AST_ONE_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_push) <= 1); // R5

endmodule

// File: tb/flash_cmd_dispatch_test.sv
// Lock-step bench: a per-bank queue/busy model predicts every output each cycle.
module flash_cmd_dispatch_test;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NB = 4;
    localparam int QD = 4;
    localparam int CW = 2 + AW + DW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_we = 1'b0;
    logic [1:0]       op_in = '0;
    logic             addr_vld = 1'b0;
    logic [AW-1:0]    addr_in = '0;
    logic [DW-1:0]    wdata_in = '0;
    logic             host_ready;
    logic             op_err;
    logic [NB-1:0]    bk_done = '0;
    logic [NB-1:0]    bk_start;
    logic [2*NB-1:0]  bk_op;
    logic [AW*NB-1:0] bk_addr;
    logic [DW*NB-1:0] bk_wdata;

    flash_cmd_dispatch #(.AW(AW), .DW(DW), .NB(NB), .QDEPTH(QD)) uut (
        .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_in(op_in),
        .addr_vld(addr_vld), .addr_in(addr_in), .wdata_in(wdata_in),
        .host_ready(host_ready), .op_err(op_err), .bk_done(bk_done),
        .bk_start(bk_start), .bk_op(bk_op), .bk_addr(bk_addr), .bk_wdata(bk_wdata)
    );

    always #10 clk = ~clk; // 50 MHz

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_tag = "R1";

    // Model state
    logic [CW-1:0] mq [NB][QD];
    int            mcnt [NB];
    bit            mbusy [NB];
    int            cd [NB];
    bit            hold [NB];
    bit            mloaded, marmed;
    logic [1:0]    mop;
    logic [AW-1:0] mlast;
    bit            e_start [NB];
    logic [CW-1:0] e_cmd [NB];
    string         e_tag [NB];
    bit            e_err;

    function automatic bit model_ready();
        for (int b = 0; b < NB; b++) if (mcnt[b] >= QD) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            mcnt[b] = 0; mbusy[b] = 0; cd[b] = 0; hold[b] = 0;
            e_start[b] = 0; e_cmd[b] = '0; e_tag[b] = "R1";
        end
        mloaded = 0; marmed = 0; mop = 2'b00; mlast = '0; e_err = 0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (%s) cycle %0d: actual=%0h expected=%0h", tag, cur_tag, cycles, act, exp);
        end
    endtask

    // Compare outputs with the prediction made for this cycle.
    task automatic compare();
        check("R9", 32'(host_ready), 32'(model_ready()));
        check("R2", 32'(op_err), 32'(e_err));
        for (int b = 0; b < NB; b++) begin
            check(e_start[b] ? e_tag[b] : "R11", 32'(bk_start[b]), 32'(e_start[b]));
            if (e_start[b] && bk_start[b]) begin
                check("R5", 32'(bk_op[2*b +: 2]), 32'(e_cmd[b][CW-1 -: 2]));
                check(e_tag[b] == "R7" ? "R8" : "R5", 32'(bk_addr[AW*b +: AW]), 32'(e_cmd[b][DW +: AW]));
                check("R5", 32'(bk_wdata[DW*b +: DW]), 32'(e_cmd[b][DW-1:0]));
            end
        end
    endtask

    // Advance the model over one clock edge with the current inputs.
    task automatic step();
        bit            rdy, fire;
        logic [1:0]    fb;
        logic [CW-1:0] inc;
        int            nstart;
        rdy  = model_ready();
        fire = addr_vld && rdy && mloaded && (marmed || addr_in != mlast);
        fb   = addr_in[AW-1 -: 2];
        inc  = {mop, addr_in, wdata_in};
        nstart = 0;
        for (int b = 0; b < NB; b++) begin
            bit free, here, byp;
            free = !mbusy[b] || bk_done[b];
            here = fire && (fb == 2'(b));
            byp  = 0;
            e_start[b] = 0;
            if (free && mcnt[b] > 0) begin
                e_start[b] = 1; e_cmd[b] = mq[b][0]; e_tag[b] = "R7";
                for (int i = 0; i < QD - 1; i++) mq[b][i] = mq[b][i+1];
                mcnt[b]--;
            end else if (free && here) begin
                e_start[b] = 1; e_cmd[b] = inc; e_tag[b] = "R6"; byp = 1;
            end
            if (here && !byp) begin
                mq[b][mcnt[b]] = inc; mcnt[b]++;
            end
            if (e_start[b]) begin
                mbusy[b] = 1; cd[b] = 1 + int'($urandom % 6); nstart++;
            end else if (bk_done[b]) begin
                mbusy[b] = 0;
            end
        end
        if (nstart > 1) for (int b = 0; b < NB; b++) if (e_start[b]) e_tag[b] = "R10";
        e_err = op_we && (op_in == 2'b11);
        if (fire) begin mlast = addr_in; marmed = 0; end
        if (op_we && op_in != 2'b11) begin mop = op_in; mloaded = 1; marmed = 1; end
    endtask

    // One cycle: check, drive host inputs and local-controller completions, predict.
    task automatic cyc(input bit we, input logic [1:0] o, input bit av,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cycles++;
        compare();
        op_we = we; op_in = o; addr_vld = av; addr_in = a; wdata_in = d;
        for (int b = 0; b < NB; b++) begin
            bk_done[b] = 1'b0;
            if (mbusy[b]) begin
                if (cd[b] == 0 && !hold[b]) bk_done[b] = 1'b1;
                else if (cd[b] > 0) cd[b]--;
            end
        end
        step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 2'b00, 0, '0, '0);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state checked by the first comparisons
        cur_tag = "R1";
        idle(2);
        // R4: address before any opcode is ignored
        cur_tag = "R4";
        cyc(0, 2'b00, 1, 8'h05, 8'h11);
        idle(2);
        // R2: reserved code pulses error and leaves nothing loaded
        cur_tag = "R2";
        cyc(1, 2'b11, 0, '0, '0);
        cyc(0, 2'b00, 1, 8'h06, 8'h12);
        idle(2);
        // R6 and R5: read to idle bank 0 launches next cycle
        cur_tag = "R6";
        for (int b = 0; b < NB; b++) hold[b] = 1;
        cyc(1, 2'b00, 0, '0, '0);
        cyc(0, 2'b00, 1, 8'h05, 8'hA5);
        // R3: same address again is not a new command
        cur_tag = "R3";
        cyc(0, 2'b00, 1, 8'h05, 8'hA5);
        cyc(0, 2'b00, 1, 8'h05, 8'hA5);
        // R3: rearm by opcode write allows the same address
        cyc(1, 2'b10, 0, '0, '0);
        cyc(0, 2'b00, 1, 8'h05, 8'h5A);
        // R9: fill bank 1 then present more addresses while not ready
        cur_tag = "R9";
        cyc(1, 2'b01, 0, '0, '0);
        for (int i = 0; i < 6; i++) cyc(0, 2'b00, 1, 8'h40 + 8'(i), 8'(i * 7));
        cyc(0, 2'b00, 1, 8'h80, 8'h33);
        idle(2);
        // R7 and R8: release banks, queued commands drain in order
        cur_tag = "R8";
        for (int b = 0; b < NB; b++) hold[b] = 0;
        idle(40);
        // R10: random mixed traffic with random local latencies
        cur_tag = "R10";
        for (int i = 0; i < 5000; i++) begin
            bit we, av;
            we = ($urandom % 12) == 0;
            av = ($urandom % 3) != 0;
            cyc(we, 2'($urandom), av, {2'($urandom), 4'b0000, 2'($urandom)}, 8'($urandom));
        end
        cur_tag = "R7";
        idle(60);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule